// File: doc/BRIEF.md
# Two-Channel Temperature Register Bank with Read Interlock

This block is the byte-wide register file of a two-channel temperature monitor. Conversion logic writes a fresh 11-bit reading for the internal sensor and another for the external sensor when it pulses an update strobe. In the same cycle it can raise event flags. A host reads the block one byte at a time through an address, a read strobe and a registered data output. The read data appears one cycle after the strobe.

Each reading is split across two bytes. The high byte carries the integer part. The low byte carries a three-bit fraction, left-justified. A read of a channel's high byte copies that channel's current low byte into a per-channel shadow, and the low-byte address always returns the shadow. This keeps a high/low pair coherent even when an update lands between the two reads. A status byte collects sticky event bits, which clear when the status byte is read, plus a live busy bit. Two outputs, alert and therm, are derived from those sticky bits. Three fixed identification bytes complete the map.

Top module: `tsr_bank`

## Requirements
- R1: After reset `rd_data`, `alert_o` and `therm_o` are 0. The temperature bytes, the shadows and the sticky status bits are all 00h.
- R2: `rd_data` is registered. It shows the addressed byte in the cycle after `rd_en` is high, and it holds its value in cycles without `rd_en`.
- R3: On `upd_en` both channels capture `int_temp` and `ext_temp`. Address 00h returns bits 10:3 of the internal reading and address 01h returns bits 10:3 of the external reading.
- R4: A read of 00h (or 01h) copies `{temp[2:0], 5'b0}` of that channel's current reading into its shadow. Address 29h returns the internal shadow and 10h returns the external shadow.
- R5: An update between a high-byte read and the next low-byte read does not change the low byte returned. A repeated high-byte read refreshes the shadow.
- R6: Address 02h returns status in this bit order, bit 7 down to bit 0: busy, int-high, int-low, ext-high, ext-low, fault, ext-therm, int-therm. Bit 7 is the live `busy_in` value.
- R7: `evt_flags[6:0]` maps to status bits 6:0 in that order. A flag sets its sticky bit on `upd_en`, and the bit clears on a read of 02h. A flag arriving in the same cycle as the clearing read leaves the bit set.
- R8: `alert_o` is the OR of sticky bits 6:2. `therm_o` is the OR of sticky bits 1:0.
- R9: Addresses FDh, FEh and FFh return 20h, 5Dh and 04h.
- R10: Any other address returns 00h, clears no status bit and refreshes no shadow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Registered read data |
| upd_en | input | 1 | Update strobe from the conversion logic |
| int_temp | input | 11 | New internal reading, 8.3 fixed point |
| ext_temp | input | 11 | New external reading, 8.3 fixed point |
| evt_flags | input | 7 | Event flags, captured into status bits 6:0 |
| busy_in | input | 1 | Live conversion-in-progress flag |
| alert_o | output | 1 | Active-high alert, from sticky bits 6:2 |
| therm_o | output | 1 | Active-high thermal output, from sticky bits 1:0 |

## Verification
The assertions check, on every cycle, the following:
- the registered read timing and data hold;
- the fixed identification values;
- zeros on unmapped reads;
- the setting of alert and therm from event flags;
- their clearing by a status read that has no new event;
- their persistence when no status read occurs.

Shadow coherency depends on a history of reads and updates, so only the bench scenarios can show it: a high read, then an update, then a low read, and the refresh by a repeated high read. The same holds for the same-cycle set-versus-clear race on the status register and the exact bit order of the status byte.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 8;
  localparam int EVT_W  = 7;

  localparam logic [ADDR_W-1:0] A_INT_HI = 8'h00;
  localparam logic [ADDR_W-1:0] A_EXT_HI = 8'h01;
  localparam logic [ADDR_W-1:0] A_STAT   = 8'h02;
  localparam logic [ADDR_W-1:0] A_EXT_LO = 8'h10;
  localparam logic [ADDR_W-1:0] A_INT_LO = 8'h29;
  localparam logic [ADDR_W-1:0] A_PROD   = 8'hFD;
  localparam logic [ADDR_W-1:0] A_MFR    = 8'hFE;
  localparam logic [ADDR_W-1:0] A_REV    = 8'hFF;

  localparam logic [DATA_W-1:0] V_PROD = 8'h20;
  localparam logic [DATA_W-1:0] V_MFR  = 8'h5D;
  localparam logic [DATA_W-1:0] V_REV  = 8'h04;

  // sticky status masks (bit 6..2 feed alert, 1..0 feed therm)
  localparam logic [EVT_W-1:0] ALERT_MASK = 7'b111_1100;
  localparam logic [EVT_W-1:0] THERM_MASK = 7'b000_0011;

  function automatic logic [ADDR_W-1:0] hi_addr(input int ch);
    return (ch == 0) ? A_INT_HI : A_EXT_HI;
  endfunction

  function automatic logic [ADDR_W-1:0] lo_addr(input int ch);
    return (ch == 0) ? A_INT_LO : A_EXT_LO;
  endfunction
endpackage

// File: rtl/tsr_rst_sync.sv
module tsr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/tsr_channel.sv
module tsr_channel #(
  parameter int TEMP_W = 11,
  parameter int FRAC_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [TEMP_W-1:0] temp_in,
  input  logic              hi_rd,
  output logic [DATA_W-1:0] hi_byte,
  output logic [DATA_W-1:0] lo_shadow
);
  localparam int INT_W = TEMP_W - FRAC_W;
  localparam int PAD_W = DATA_W - FRAC_W;

  logic [TEMP_W-1:0] live_q, live_d;
  logic [FRAC_W-1:0] shd_q, shd_d;

  always_comb begin
    live_d = live_q;
    if (upd_en) live_d = temp_in;
  end

  always_comb begin
    shd_d = shd_q;
    if (hi_rd) shd_d = live_q[FRAC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
      shd_q  <= '0;
    end else begin
      live_q <= live_d;
      shd_q  <= shd_d;
    end
  end

  assign hi_byte   = DATA_W'(live_q[TEMP_W-1:FRAC_W]);
  assign lo_shadow = {shd_q, {PAD_W{1'b0}}};

  if (INT_W != DATA_W) begin : g_bad_width
    initial $error("integer part width must equal byte width");
  end
endmodule

// File: rtl/tsr_status.sv
module tsr_status
  import tsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [EVT_W-1:0]  evt_in,
  input  logic              clr_rd,
  input  logic              busy_in,
  output logic [DATA_W-1:0] stat_byte,
  output logic              alert_o,
  output logic              therm_o
);
  logic [EVT_W-1:0] sticky_q, sticky_d, set_v, keep_v;

  always_comb begin
    keep_v   = clr_rd ? '0 : sticky_q;
    set_v    = upd_en ? evt_in : '0;
    sticky_d = keep_v | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sticky_q <= '0;
    else        sticky_q <= sticky_d;
  end

  assign stat_byte = {busy_in, sticky_q};
  assign alert_o   = |(sticky_q & ALERT_MASK);
  assign therm_o   = |(sticky_q & THERM_MASK);
endmodule

// File: rtl/tsr_rdport.sv
module tsr_rdport
  import tsr_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] hi_byte [NUM_CH],
  input  logic [DATA_W-1:0] lo_byte [NUM_CH],
  input  logic [DATA_W-1:0] stat_byte,
  output logic [NUM_CH-1:0] hi_rd,
  output logic              stat_rd,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] sel_v, rdata_d, rdata_q;

  always_comb begin
    sel_v = '0;
    unique case (rd_addr)
      A_STAT:  sel_v = stat_byte;
      A_PROD:  sel_v = V_PROD;
      A_MFR:   sel_v = V_MFR;
      A_REV:   sel_v = V_REV;
      default: sel_v = '0;
    endcase
    for (int c = 0; c < NUM_CH; c++) begin
      if (rd_addr == hi_addr(c)) sel_v = hi_byte[c];
      if (rd_addr == lo_addr(c)) sel_v = lo_byte[c];
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_hird
    assign hi_rd[c] = rd_en && (rd_addr == hi_addr(c));
  end
  assign stat_rd = rd_en && (rd_addr == A_STAT);

  always_comb begin
    rdata_d = rdata_q;
    if (rd_en) rdata_d = sel_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign rd_data = rdata_q;
endmodule

// File: rtl/tsr_bank.sv
module tsr_bank
  import tsr_pkg::*;
#(
  parameter int TEMP_W = 11,
  parameter int FRAC_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              upd_en,
  input  logic [TEMP_W-1:0] int_temp,
  input  logic [TEMP_W-1:0] ext_temp,
  input  logic [EVT_W-1:0]  evt_flags,
  input  logic              busy_in,
  output logic              alert_o,
  output logic              therm_o
);
  localparam int NUM_CH = 2;

  logic              rst_sync_n;
  logic [TEMP_W-1:0] temp_v  [NUM_CH];
  logic [DATA_W-1:0] hi_v    [NUM_CH];
  logic [DATA_W-1:0] lo_v    [NUM_CH];
  logic [NUM_CH-1:0] hi_rd;
  logic              stat_rd;
  logic [DATA_W-1:0] stat_byte;

  assign temp_v[0] = int_temp;
  assign temp_v[1] = ext_temp;

  tsr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tsr_channel #(.TEMP_W(TEMP_W), .FRAC_W(FRAC_W), .DATA_W(DATA_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .upd_en   (upd_en),
      .temp_in  (temp_v[c]),
      .hi_rd    (hi_rd[c]),
      .hi_byte  (hi_v[c]),
      .lo_shadow(lo_v[c])
    );
  end

  tsr_status u_stat (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .upd_en   (upd_en),
    .evt_in   (evt_flags),
    .clr_rd   (stat_rd),
    .busy_in  (busy_in),
    .stat_byte(stat_byte),
    .alert_o  (alert_o),
    .therm_o  (therm_o)
  );

  tsr_rdport #(.NUM_CH(NUM_CH)) u_rd (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .hi_byte  (hi_v),
    .lo_byte  (lo_v),
    .stat_byte(stat_byte),
    .hi_rd    (hi_rd),
    .stat_rd  (stat_rd),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/tsr_bank_chk.sv
module tsr_bank_chk
  import tsr_pkg::*;
(
  input logic              clk,
  input logic              rst_sync_n,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              upd_en,
  input logic [EVT_W-1:0]  evt_flags,
  input logic              alert_o,
  input logic              therm_o
);
  logic mapped, st_rd;
  assign mapped = (rd_addr inside {A_INT_HI, A_EXT_HI, A_STAT, A_EXT_LO,
                                   A_INT_LO, A_PROD, A_MFR, A_REV});
  assign st_rd  = rd_en && (rd_addr == A_STAT);

  assert_rd_hold_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rd_en |=> $stable(rd_data));

  assert_prod_id_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_en && rd_addr == A_PROD) |=> rd_data == V_PROD);

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_en && !mapped) |=> rd_data == '0);

  assert_alert_set_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (upd_en && |(evt_flags & ALERT_MASK)) |=> alert_o);

  assert_therm_set_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (upd_en && |(evt_flags & THERM_MASK)) |=> therm_o);

  assert_clear_on_read_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (st_rd && !upd_en) |=> (!alert_o && !therm_o));

  assert_alert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (alert_o && !st_rd) |=> alert_o);
endmodule

bind tsr_bank tsr_bank_chk u_chk (
  .clk       (clk),
  .rst_sync_n(rst_sync_n),
  .rd_en     (rd_en),
  .rd_addr   (rd_addr),
  .rd_data   (rd_data),
  .upd_en    (upd_en),
  .evt_flags (evt_flags),
  .alert_o   (alert_o),
  .therm_o   (therm_o)
);

// File: tb/tsr_bank_tb_top.sv
module tsr_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rd_en;
  logic [7:0]  rd_addr;
  logic [7:0]  rd_data;
  logic        upd_en;
  logic [10:0] int_temp, ext_temp;
  logic [6:0]  evt_flags;
  logic        busy_in;
  logic        alert_o, therm_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  tsr_bank dut_i (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .upd_en(upd_en), .int_temp(int_temp), .ext_temp(ext_temp),
    .evt_flags(evt_flags), .busy_in(busy_in), .alert_o(alert_o), .therm_o(therm_o)
  );

  typedef struct packed {
    logic        upd;
    logic [10:0] it;
    logic [10:0] et;
    logic        rd;
    logic [7:0]  addr;
    logic [7:0]  exp;
  } vec_t;

  // int 0x5A3 -> hi B4 lo 60 ; int 0x0A1 -> hi 14 lo 20
  // ext 0x1F7 -> hi 3E lo E0 ; ext 0x002 -> hi 00 lo 40
  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 11'h5A3, 11'h1F7, 1'b0, 8'h00, 8'h00},
    '{1'b0, 11'h000, 11'h000, 1'b1, 8'h00, 8'hB4}, // R3
    '{1'b1, 11'h0A1, 11'h1F7, 1'b0, 8'h00, 8'h00},
    '{1'b0, 11'h000, 11'h000, 1'b1, 8'h29, 8'h60}, // R5 update between
    '{1'b0, 11'h000, 11'h000, 1'b1, 8'h00, 8'h14}, // R3
    '{1'b0, 11'h000, 11'h000, 1'b1, 8'h29, 8'h20}, // R5 refresh
    '{1'b0, 11'h000, 11'h000, 1'b1, 8'h01, 8'h3E}, // R3
    '{1'b1, 11'h0A1, 11'h002, 1'b1, 8'h10, 8'hE0}, // R4 / R5
    '{1'b0, 11'h000, 11'h000, 1'b1, 8'h01, 8'h00}, // R3
    '{1'b0, 11'h000, 11'h000, 1'b1, 8'h10, 8'h40}, // R4
    '{1'b0, 11'h000, 11'h000, 1'b1, 8'hFD, 8'h20}, // R9
    '{1'b0, 11'h000, 11'h000, 1'b1, 8'hFE, 8'h5D}, // R9
    '{1'b0, 11'h000, 11'h000, 1'b1, 8'hFF, 8'h04}, // R9
    '{1'b0, 11'h000, 11'h000, 1'b1, 8'h03, 8'h00}, // R10
    '{1'b0, 11'h000, 11'h000, 1'b1, 8'h11, 8'h00}  // R10
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    rd_en = 0; upd_en = 0; evt_flags = '0;
  endtask

  // drive at negedge, sample at following negedge
  task automatic step(input logic u, input logic [6:0] ev, input logic r,
                      input logic [7:0] a, input logic b);
    upd_en = u; evt_flags = ev; rd_en = r; rd_addr = a; busy_in = b;
    @(negedge clk);
    idle();
  endtask

  task automatic do_reset();
    rst_n = 0; idle(); rd_addr = '0; busy_in = 0; int_temp = '0; ext_temp = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 alert", {7'd0, alert_o}, 8'h00);
    chk("R1 therm", {7'd0, therm_o}, 8'h00);
    step(0, 0, 1, 8'h29, 0); chk("R1 int shadow", rd_data, 8'h00);
    step(0, 0, 1, 8'h00, 0); chk("R1 int hi", rd_data, 8'h00);
    step(0, 0, 1, 8'h02, 0); chk("R1 status", rd_data, 8'h00);

    // vector table
    for (int i = 0; i < NV; i++) begin
      int_temp = VEC[i].it; ext_temp = VEC[i].et;
      step(VEC[i].upd, 7'd0, VEC[i].rd, VEC[i].addr, 0);
      if (VEC[i].rd) chk($sformatf("R3/R4/R5/R9/R10 vec%0d", i), rd_data, VEC[i].exp);
    end

    // R2 hold without read
    repeat (3) @(negedge clk);
    chk("R2 hold", rd_data, 8'h00);
    step(0, 0, 1, 8'hFE, 0);
    repeat (2) @(negedge clk);
    chk("R2 hold after read", rd_data, 8'h5D);

    // R7/R8 status
    step(1, 7'b100_0000, 0, 8'h00, 0);
    chk("R8 alert set", {7'd0, alert_o}, 8'h01);
    chk("R8 therm idle", {7'd0, therm_o}, 8'h00);
    step(0, 0, 1, 8'h05, 0);                       // R10 no side effect
    chk("R10 unmapped keeps alert", {7'd0, alert_o}, 8'h01);
    step(0, 0, 1, 8'h02, 1);
    chk("R6 status busy+ihigh", rd_data, 8'hC0);
    chk("R7 cleared alert", {7'd0, alert_o}, 8'h00);
    step(0, 0, 1, 8'h02, 1);
    chk("R6 busy live", rd_data, 8'h80);
    step(1, 7'b000_0001, 0, 8'h00, 0);
    chk("R8 therm set", {7'd0, therm_o}, 8'h01);
    chk("R8 alert not from therm bit", {7'd0, alert_o}, 8'h00);
    step(1, 7'b000_0010, 1, 8'h02, 0);             // race: set wins
    chk("R7 race read old", rd_data, 8'h01);
    chk("R7 race therm kept", {7'd0, therm_o}, 8'h01);
    step(0, 0, 1, 8'h02, 0);
    chk("R7 race bit kept", rd_data, 8'h02);
    chk("R8 therm clear", {7'd0, therm_o}, 8'h00);
    step(1, 7'b000_1000, 0, 8'h00, 0);
    step(0, 0, 1, 8'h02, 0);
    chk("R6 ext-low bit 3", rd_data, 8'h08);

    // R10 unmapped read does not refresh shadow
    int_temp = 11'h7FF; ext_temp = 11'h000;
    step(1, 0, 0, 8'h00, 0);
    step(0, 0, 1, 8'h28, 0);
    chk("R10 unmapped zero", rd_data, 8'h00);
    step(0, 0, 1, 8'h29, 0);
    chk("R10 shadow untouched", rd_data, 8'h20);
    step(0, 0, 1, 8'h00, 0);
    step(0, 0, 1, 8'h29, 0);
    chk("R4 full fraction", rd_data, 8'hE0);

    // R1 mid-run reset
    step(1, 7'b111_1111, 0, 8'h00, 0);
    do_reset();
    chk("R1 again rd_data", rd_data, 8'h00);
    chk("R1 again alert", {7'd0, alert_o}, 8'h00);
    step(0, 0, 1, 8'h29, 0);
    chk("R1 again shadow", rd_data, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule